// File: doc/BRIEF.md
# Multi-Bank Chip Select Address Decoder

This block decides which memory bank owns each bus cycle. Twelve bank descriptors are held inside it. Each descriptor is a pair of 32-bit registers: a base word and an options word. The base word carries the bank start address, a code for the transfer machine that should run the cycle, four attribute bits and a valid flag. The options word carries an address mask, which sets the bank size, and four further attribute bits. When a request arrives, its address is compared against every valid bank in parallel. The lowest-numbered matching bank wins. One clock later the block drives that bank's one-hot chip select, its machine code and its combined attributes. If no valid bank claims the address, the block instead raises a no-match flag, so the bus can end the cycle with an error.

The block comes out of reset in a bootable state. Bank 0 is already valid, has a zero mask and uses machine code 0, so it answers every address and the boot code can fetch through it. The other eleven banks stay disabled until software programs them. Software uses a simple write/read port to program the pairs, and it may later shrink or move bank 0.

Base word layout: address bits [31:15], machine code [7:5], base attributes [4:1] and valid [0]. Options word layout: mask bits [31:15] and options attributes [3:0]. All other bits are reserved. Reserved bits are dropped on write and read back as zero.

Top module: `cs_bank_decoder`

## Requirements
- R1: After reset, the base word of bank 0 reads 0x00000001 (valid, start 0, machine code 0). The options word of bank 0 reads 0x00000000, and every word of banks 1 to 11 reads 0.
- R2: After reset, with no programming, a request at any address yields chip select 0x001, hit_o=1, miss_o=0 and machine code 0.
- R3: A valid bank matches when the request address and the base address agree on every bit in [31:15] where the options mask has a 1. Address bits [14:0] never affect the match.
- R4: A bank whose base word has bit 0 clear never matches, whatever its address and mask.
- R5: When several valid banks match, only the lowest-numbered one asserts its chip select, and the outputs carry that bank's fields.
- R6: When no valid bank matches a request, cs_o is all zero, hit_o=0, msel_o=0, attr_o=0 and miss_o=1.
- R7: The decode result for a request sampled at a clock edge appears on the outputs right after the next edge. In a cycle that follows a clock with no request, cs_o, hit_o and miss_o are all zero.
- R8: On a hit, msel_o is base bits [7:5] and attr_o is {base bits [4:1], options bits [3:0]} of the winning bank.
- R9: A register write takes effect for a request sampled on the clock edge after the write. This includes a rewrite of bank 0 that shrinks or moves its range.
- R10: reg_rdata shows the addressed word one clock after reg_idx/reg_sel_opt are applied, with reserved bits at zero. reg_sel_opt=1 selects the options word.
- R11: A write or read with reg_idx of 12 or more has no effect, and the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the descriptor port |
| reg_sel_opt | input | 1 | 0 selects the base word, 1 selects the options word |
| reg_idx | input | 4 | Bank index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Bus cycle request |
| req_addr | input | 32 | Bus cycle address |
| cs_o | output | 12 | One-hot chip select vector |
| msel_o | output | 3 | Machine code of the winning bank |
| attr_o | output | 8 | Combined access attributes of the winning bank |
| hit_o | output | 1 | A valid bank matched the request |
| miss_o | output | 1 | The request matched no valid bank |

## Verification
The bench targets several corner cases and what a wrong design would do in each:
- Overlapping valid banks: a design with reversed priority would assert the higher-numbered chip select or several at once.
- A bank left invalid but carrying a matching address: a design that ignores the valid flag would claim the cycle.
- Addresses one step either side of a mask boundary, plus low address bits toggled inside a window: these expose a design that compares bits below bit 15 or applies the mask to only one operand.
- A bank 0 rewrite followed at once by a request, and writes to indices 12 to 15: these catch stale decode state and aliased writes.

Randomly programmed banks and random addresses, many of them steered into existing windows, cover machine-code and attribute routing.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int ADDR_W    = 32;
  localparam int MATCH_LSB = 15;
  localparam int MSEL_W    = 3;
  localparam int BATTR_W   = 4;
  localparam int OATTR_W   = 4;
  localparam int ATTR_W    = BATTR_W + OATTR_W;

  // base word field positions
  localparam int B_VALID   = 0;
  localparam int B_ATTR_LO = 1;
  localparam int B_MSEL_LO = B_ATTR_LO + BATTR_W;

  localparam logic [ADDR_W-1:0] HI_MASK   = {ADDR_W{1'b1}} << MATCH_LSB;
  localparam logic [ADDR_W-1:0] BASE_KEEP =
    HI_MASK | ADDR_W'((64'd1 << (B_MSEL_LO + MSEL_W)) - 64'd1);
  localparam logic [ADDR_W-1:0] OPT_KEEP  =
    HI_MASK | ADDR_W'((64'd1 << OATTR_W) - 64'd1);

  typedef enum logic [MSEL_W-1:0] {
    MSEL_GENERIC = 3'd0,
    MSEL_ALT1    = 3'd1,
    MSEL_ALT2    = 3'd2
  } msel_e;

  // boot bank: valid, start 0, generic machine, mask 0 (whole space)
  localparam logic [ADDR_W-1:0] BOOT_BASE_RST =
    ADDR_W'(1) << B_VALID | (ADDR_W'(MSEL_GENERIC) << B_MSEL_LO);
  localparam logic [ADDR_W-1:0] BOOT_OPT_RST  = '0;
endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic                                sel_opt,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [ADDR_W-1:0]                   wdata,
  output logic [ADDR_W-1:0]                   rdata,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0]    base_q,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0]    opt_q
);
  logic idx_ok;
  assign idx_ok = (32'(idx) < NUM_BANKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        base_q[i] <= (i == 0) ? BOOT_BASE_RST : '0;
        opt_q[i]  <= (i == 0) ? BOOT_OPT_RST  : '0;
      end
      rdata <= '0;
    end else begin
      if (wr_en && idx_ok) begin
        if (sel_opt) opt_q[idx]  <= wdata & OPT_KEEP;
        else         base_q[idx] <= wdata & BASE_KEEP;
      end
      if (!idx_ok)      rdata <= '0;
      else if (sel_opt) rdata <= opt_q[idx];
      else              rdata <= base_q[idx];
    end
  end
endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 12
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_BANKS-1:0][ADDR_W-1:0] base_q,
  input  logic [NUM_BANKS-1:0][ADDR_W-1:0] opt_q,
  output logic [NUM_BANKS-1:0]             match
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    logic [ADDR_W-1:0] diff;
    assign diff     = (addr ^ base_q[g]) & opt_q[g] & HI_MASK;
    assign match[g] = base_q[g][B_VALID] && (diff == '0);
  end
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_BANKS-1:0] match,
  output logic [NUM_BANKS-1:0] onehot,
  output logic [IDX_W-1:0]     win_idx,
  output logic                 any
);
  always_comb begin
    onehot  = '0;
    win_idx = '0;
    any     = |match;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (match[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic                 reg_sel_opt,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic [ADDR_W-1:0]    reg_wdata,
  output logic [ADDR_W-1:0]    reg_rdata,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic [MSEL_W-1:0]    msel_o,
  output logic [ATTR_W-1:0]    attr_o,
  output logic                 hit_o,
  output logic                 miss_o
);
  logic [NUM_BANKS-1:0][ADDR_W-1:0] base_q;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] opt_q;
  logic [NUM_BANKS-1:0]             match;
  logic [NUM_BANKS-1:0]             onehot;
  logic [IDX_W-1:0]                 win_idx;
  logic                             any;
  logic [ADDR_W-1:0]                win_base;
  logic [ADDR_W-1:0]                win_opt;

  cs_bank_regs #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .sel_opt(reg_sel_opt),
    .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
    .base_q(base_q), .opt_q(opt_q)
  );

  cs_bank_match #(.NUM_BANKS(NUM_BANKS)) match_i (
    .addr(req_addr), .base_q(base_q), .opt_q(opt_q), .match(match)
  );

  cs_prio_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) pick_i (
    .match(match), .onehot(onehot), .win_idx(win_idx), .any(any)
  );

  always_comb begin
    win_base = '0;
    win_opt  = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (onehot[i]) begin
        win_base = base_q[i];
        win_opt  = opt_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      cs_o   <= '0;
      msel_o <= '0;
      attr_o <= '0;
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
    end else begin
      cs_o   <= onehot;
      msel_o <= win_base[B_MSEL_LO +: MSEL_W];
      attr_o <= {win_base[B_ATTR_LO +: BATTR_W], win_opt[OATTR_W-1:0]};
      hit_o  <= any;
      miss_o <= !any;
    end
  end
endmodule

// File: rtl/cs_bank_decoder_chk.sv
module cs_bank_decoder_chk #(
  parameter int NUM_BANKS = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [NUM_BANKS-1:0] cs_o,
  input logic                 hit_o,
  input logic                 miss_o
);
  p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o));

  p_miss_no_cs_r6: assert property (@(posedge clk) disable iff (rst)
    miss_o |-> (cs_o == '0 && !hit_o));

  p_hit_has_cs_r6: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> ($countones(cs_o) == 1));

  p_answer_next_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (hit_o ^ miss_o));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (cs_o == '0 && !hit_o && !miss_o));
endmodule

bind cs_bank_decoder cs_bank_decoder_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .cs_o(cs_o), .hit_o(hit_o), .miss_o(miss_o)
);

// File: tb/cs_bank_decoder_tb.sv
module cs_bank_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel_opt = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [11:0] cs_o;
  logic [2:0]  msel_o;
  logic [7:0]  attr_o;
  logic        hit_o;
  logic        miss_o;

  int n_checks = 0;
  int n_fail   = 0;
  int unsigned seed_init;

  logic [31:0] mbase [NB];
  logic [31:0] mopt  [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_bank_decoder dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel_opt(reg_sel_opt),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .cs_o(cs_o), .msel_o(msel_o),
    .attr_o(attr_o), .hit_o(hit_o), .miss_o(miss_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] pack_out();
    return {cs_o, msel_o, attr_o, hit_o, miss_o};
  endfunction

  function automatic logic [24:0] model_out(input logic [31:0] a);
    for (int i = 0; i < NB; i++) begin
      if (mbase[i][0] && (((a ^ mbase[i]) & mopt[i] & 32'hFFFF_8000) == 0)) begin
        logic [11:0] oh;
        oh = 12'd1 << i;
        return {oh, mbase[i][7:5], mbase[i][4:1], mopt[i][3:0], 1'b1, 1'b0};
      end
    end
    return {12'd0, 3'd0, 8'd0, 1'b0, 1'b1};
  endfunction

  task automatic wr(input bit opt, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel_opt = opt; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (idx < NB) begin
      if (opt) mopt[idx]  = d & 32'hFFFF_800F;
      else     mbase[idx] = d & 32'hFFFF_80FF;
    end
  endtask

  task automatic rd(input string tag, input bit opt, input int idx, input logic [31:0] exp);
    @(negedge clk);
    reg_sel_opt = opt; reg_idx = 4'(idx);
    @(negedge clk);
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic req(input string tag, input logic [31:0] a);
    logic [24:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    e = model_out(a);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, 64'(pack_out()), 64'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    seed_init = $urandom(32'd7331);
    for (int i = 0; i < NB; i++) begin mbase[i] = '0; mopt[i] = '0; end
    mbase[0] = 32'h0000_0001;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset register state
    rd("R1 base0", 1'b0, 0, 32'h0000_0001);
    rd("R1 opt0", 1'b1, 0, 32'h0);
    rd("R1 base5", 1'b0, 5, 32'h0);
    rd("R1 opt11", 1'b1, 11, 32'h0);
    // R2 boot bank covers all addresses
    req("R2 addr0", 32'h0000_0000);
    req("R2 top", 32'hFFFF_FFFF);
    req("R2 mid", 32'h7A5C_1234);
    // R7 idle cycle after a request
    @(negedge clk);
    check("R7 idle", 64'(pack_out()), 64'd0);
    // R9 shrink bank 0 to 1 MB, request next cycle
    wr(1'b1, 0, 32'hFFF0_0000);
    req("R9 outside shrunk", 32'h0010_0000);
    req("R3 inside low", 32'h000F_FFFF);
    req("R3 low bits ignored", 32'h0000_7FFF);
    // R9 relocate bank 0
    wr(1'b0, 0, 32'h1000_0001);
    req("R9 relocated hit", 32'h1000_0040);
    req("R9 old window miss", 32'h0000_0040);
    // R5 overlap: bank 3 wide, bank 5 narrow inside it
    wr(1'b0, 3, 32'h8000_0045);   // msel 2, battr 2, valid
    wr(1'b1, 3, 32'hF000_0003);
    wr(1'b0, 5, 32'h8000_00A1);   // msel 5, valid
    wr(1'b1, 5, 32'hFFFF_8009);
    req("R5 low bank wins", 32'h8000_1000);
    req("R8 fields", 32'h8FFF_0000);
    // R4 invalid bank with matching window
    wr(1'b0, 7, 32'h4000_00E0);
    wr(1'b1, 7, 32'hF000_0000);
    req("R4 invalid bank", 32'h4000_0000);
    // R6 nothing matches
    req("R6 miss", 32'h2000_0000);
    // R11 out of range index
    wr(1'b0, 13, 32'h2000_0001);
    wr(1'b1, 12, 32'h0);
    rd("R11 read idx13", 1'b0, 13, 32'h0);
    req("R11 write ignored", 32'h2000_0000);
    // R10 readback with reserved bits dropped
    wr(1'b0, 9, 32'hFFFF_FFFF);
    rd("R10 base9", 1'b0, 9, 32'hFFFF_80FF);
    wr(1'b1, 9, 32'hFFFF_FFFF);
    rd("R10 opt9", 1'b1, 9, 32'hFFFF_800F);
    // random programming and requests
    for (int r = 0; r < 40; r++) begin
      wr($urandom_range(0, 1) == 1, $urandom_range(0, NB - 1), $urandom);
      for (int k = 0; k < 8; k++) begin
        logic [31:0] a;
        int b;
        b = $urandom_range(0, NB - 1);
        if ($urandom_range(0, 1) == 1) a = (mbase[b] & 32'hFFFF_8000) | ($urandom & 32'h0000_7FFF);
        else a = $urandom;
        req("R3 random", a);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule